// File: doc/BRIEF.md
# March-Test Memory BIST Sequencer

This engine runs a selectable march test against a synchronous single-port memory. Once started, it drives one memory operation per clock: an address, a read or write command and write data. It checks every read against the value that the current step expects. That value is either a data background word or the bitwise inverse of that word. The address range is set by a low and a high bound. A march element visits the range in ascending order (low to high) or in descending order (high to low). The one or two operations of an element run back to back on one cell before the address moves on.

Five algorithms are available: a plain initialisation, a read-and-check pass for retention testing, a four-pass scan, a five-operation-per-cell stress march, and a ten-operation-per-cell march. The engine holds the configuration it samples at start. It reports busy, then done or fail. At the first miscompare it stops and keeps the element index, address, direction, polarity and command of the failing read, together with the expected word and the word actually read.

Top module: `mbist_march_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, fail and mem_en are low and stat_cmd is 0.
- R2: Ascending elements visit addr_lo up to addr_hi and descending elements visit addr_hi down to addr_lo; the two operations of a paired element hit the same address in consecutive cycles; a range of one cell (addr_lo equal to addr_hi) works for every algorithm.
- R3: Each read is compared with the expected word one cycle later, when mem_rdata returns; the expected word is the sampled pattern for true-data steps and its bitwise inverse for inverted steps.
- R4: Code 0 (Init) writes the pattern once to every cell in ascending order; code 1 (read-check) reads and checks every cell once in ascending order; command codes are 1 for write and 3 for read-and-check, so every algorithm begins with command 1 except read-check, which begins with 3.
- R5: Code 2 (Scan) performs ascending passes of write D, read D, write inverse, read inverse, which is 4N operations.
- R6: Code 3 runs ascending write D, then ascending (read D, write inverse), then descending (read inverse, write D), which is 5N operations.
- R7: Code 4 runs ascending write D; ascending (read D, write inverse); ascending (read inverse, write D); descending (read D, write inverse); descending (read inverse, write D); and descending read D, which is 10N operations.
- R8: The first operation issues in the cycle after start is sampled, and one operation issues per cycle. Done rises two cycles after the cycle of the last operation. Codes 5 to 7 issue nothing, and done rises in the cycle after start.
- R9: On the first miscompare, fail rises and no further operation issues from the cycle in which the bad data returns. The stat outputs keep the failing read, which means its address is stat_addr. fail_exp and fail_act hold the expected and read words.
- R10: stat_elem, stat_addr, stat_dir (1 = descending), stat_inv and stat_cmd show the most recently issued operation one cycle after it issues. A new start clears fail and done, and busy is high from the cycle after start through the cycle of the final check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when not busy |
| alg_sel | input | 3 | Algorithm code |
| pattern | input | DW | Data background |
| addr_lo | input | AW | Lowest address of the range |
| addr_hi | input | AW | Highest address of the range |
| mem_en | output | 1 | Memory operation valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test completed without miscompare |
| fail | output | 1 | Test halted on miscompare |
| stat_elem | output | 3 | March element index of last operation |
| stat_addr | output | AW | Address of last operation |
| stat_dir | output | 1 | Direction of last operation |
| stat_inv | output | 1 | Polarity of last operation |
| stat_cmd | output | 2 | Command code of last operation |
| fail_exp | output | DW | Expected word of failing read |
| fail_act | output | DW | Word read at the failure |

## Verification
Start is sampled at a rising edge. Operations are due on the memory port from the next cycle, one per cycle. Each operation shows on the stat outputs one cycle after it issues. A read's verdict comes one cycle after the read issues, and done or fail appears two cycles after the cycle of the last or failing operation. The bench drives inputs and samples outputs at the falling edge and counts those edges from start. For every operation it compares the port values with a queue that a behavioural model built from loops over the march elements, and it compares the stat outputs with the queue entry of the previous cycle. The cycle count at which done or fail arrives is checked against the queue length plus two.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam logic [1:0] CMD_NONE  = 2'b00;
  localparam logic [1:0] CMD_WR    = 2'b01;
  localparam logic [1:0] CMD_RDCHK = 2'b11;

  // one march element: direction, one or two ops, each read/write and polarity
  typedef struct packed {
    logic valid;
    logic down;
    logic pair;
    logic rd0;
    logic inv0;
    logic rd1;
    logic inv1;
  } elem_t;

  function automatic elem_t elem_mk(input logic down, input logic pair,
                                    input logic rd0, input logic inv0,
                                    input logic rd1, input logic inv1);
    elem_t e;
    e.valid = 1'b1;
    e.down  = down;
    e.pair  = pair;
    e.rd0   = rd0;
    e.inv0  = inv0;
    e.rd1   = rd1;
    e.inv1  = inv1;
    return e;
  endfunction

  // algorithm codes: 0 init, 1 read-check, 2 scan, 3 five-op march, 4 ten-op march
  function automatic elem_t march_elem(input logic [2:0] alg, input logic [2:0] idx);
    elem_t e;
    e = '0;
    case (alg)
      3'd0: if (idx == 3'd0) e = elem_mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      3'd1: if (idx == 3'd0) e = elem_mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      3'd2: begin
        case (idx)
          3'd0: e = elem_mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
          3'd1: e = elem_mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
          3'd2: e = elem_mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
          3'd3: e = elem_mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
          default: e = '0;
        endcase
      end
      3'd3: begin
        case (idx)
          3'd0: e = elem_mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
          3'd1: e = elem_mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
          3'd2: e = elem_mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
          default: e = '0;
        endcase
      end
      3'd4: begin
        case (idx)
          3'd0: e = elem_mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
          3'd1: e = elem_mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
          3'd2: e = elem_mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
          3'd3: e = elem_mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
          3'd4: e = elem_mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
          3'd5: e = elem_mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
          default: e = '0;
        endcase
      end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mbist_elem_rom.sv
module mbist_elem_rom
  import mbist_pkg::*;
(
  input  logic [2:0] alg,
  input  logic [2:0] idx,
  output elem_t      desc
);
  assign desc = march_elem(alg, idx);
endmodule

// File: rtl/mbist_addr_step.sv
module mbist_addr_step #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          down,
  output logic [AW-1:0] nxt,
  output logic          at_end
);
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic dn);
    return dn ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic last_addr(input logic [AW-1:0] a, input logic [AW-1:0] l,
                                     input logic [AW-1:0] h, input logic dn);
    return dn ? (a == l) : (a == h);
  endfunction

  assign nxt    = step_addr(cur, down);
  assign at_end = last_addr(cur, lo, hi, down);
endmodule

// File: rtl/mbist_rd_check.sv
module mbist_rd_check #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_rd,
  input  logic [DW-1:0] exp_in,
  input  logic [DW-1:0] rdata,
  output logic          miscmp,
  output logic [DW-1:0] exp_q
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      pend_q <= issue_rd;
      if (issue_rd) exp_q <= exp_in;
    end
  end

  assign miscmp = pend_q && (rdata != exp_q);
endmodule

// File: rtl/mbist_march_seq.sv
module mbist_march_seq
  import mbist_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    alg_sel,
  input  logic [DW-1:0] pattern,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [2:0]    stat_elem,
  output logic [AW-1:0] stat_addr,
  output logic          stat_dir,
  output logic          stat_inv,
  output logic [1:0]    stat_cmd,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);
  localparam int EW = 3;

  logic [2:0]    alg_q;
  logic [DW-1:0] pat_q;
  logic [AW-1:0] lo_q, hi_q, addr_q;
  logic [EW-1:0] elem_q;
  logic          opk_q, running_q, drain_q, done_q, fail_q;

  elem_t         cur_d, nxt_d, first_d;
  logic [EW-1:0] elem_inc;
  logic [AW-1:0] addr_nxt;
  logic          at_end;
  logic          op_rd, op_inv, cell_last;
  logic [DW-1:0] op_data, rd_exp;
  logic          issue, issue_rd, miscmp, start_ok;

  assign elem_inc = elem_q + 3'd1;

  mbist_elem_rom u_rom_cur   (.alg(alg_q),   .idx(elem_q),   .desc(cur_d));
  mbist_elem_rom u_rom_nxt   (.alg(alg_q),   .idx(elem_inc), .desc(nxt_d));
  mbist_elem_rom u_rom_first (.alg(alg_sel), .idx(3'd0),     .desc(first_d));

  mbist_addr_step #(.AW(AW)) u_step (
    .cur(addr_q), .lo(lo_q), .hi(hi_q), .down(cur_d.down),
    .nxt(addr_nxt), .at_end(at_end)
  );

  assign op_rd     = opk_q ? cur_d.rd1  : cur_d.rd0;
  assign op_inv    = opk_q ? cur_d.inv1 : cur_d.inv0;
  assign op_data   = op_inv ? ~pat_q : pat_q;
  assign cell_last = !cur_d.pair || opk_q;

  // a miscompare seen this cycle blocks the operation that would follow it
  assign issue    = running_q && !miscmp;
  assign issue_rd = issue && op_rd;

  mbist_rd_check #(.DW(DW)) u_chk_rd (
    .clk(clk), .rst_n(rst_n), .issue_rd(issue_rd), .exp_in(op_data),
    .rdata(mem_rdata), .miscmp(miscmp), .exp_q(rd_exp)
  );

  assign mem_en    = issue;
  assign mem_we    = issue && !op_rd;
  assign mem_addr  = addr_q;
  assign mem_wdata = op_data;

  assign busy     = running_q || drain_q;
  assign done     = done_q;
  assign fail     = fail_q;
  assign start_ok = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_q <= '0; pat_q <= '0; lo_q <= '0; hi_q <= '0; addr_q <= '0;
      elem_q <= '0; opk_q <= 1'b0;
      running_q <= 1'b0; drain_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0;
      stat_elem <= '0; stat_addr <= '0; stat_dir <= 1'b0; stat_inv <= 1'b0;
      stat_cmd <= CMD_NONE; fail_exp <= '0; fail_act <= '0;
    end else if (start_ok) begin
      alg_q     <= alg_sel;
      pat_q     <= pattern;
      lo_q      <= addr_lo;
      hi_q      <= addr_hi;
      elem_q    <= '0;
      opk_q     <= 1'b0;
      addr_q    <= first_d.down ? addr_hi : addr_lo;
      running_q <= first_d.valid;
      done_q    <= !first_d.valid;
      drain_q   <= 1'b0;
      fail_q    <= 1'b0;
    end else if (running_q) begin
      if (miscmp) begin
        running_q <= 1'b0;
        fail_q    <= 1'b1;
        fail_exp  <= rd_exp;
        fail_act  <= mem_rdata;
      end else begin
        stat_elem <= elem_q;
        stat_addr <= addr_q;
        stat_dir  <= cur_d.down;
        stat_inv  <= op_inv;
        stat_cmd  <= op_rd ? CMD_RDCHK : CMD_WR;
        if (!cell_last) begin
          opk_q <= 1'b1;
        end else begin
          opk_q <= 1'b0;
          if (!at_end) begin
            addr_q <= addr_nxt;
          end else if (nxt_d.valid) begin
            elem_q <= elem_inc;
            addr_q <= nxt_d.down ? hi_q : lo_q;
          end else begin
            running_q <= 1'b0;
            drain_q   <= 1'b1;
          end
        end
      end
    end else if (drain_q) begin
      drain_q <= 1'b0;
      if (miscmp) begin
        fail_q   <= 1'b1;
        fail_exp <= rd_exp;
        fail_act <= mem_rdata;
      end else begin
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbist_march_seq_chk.sv
module mbist_march_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q,
  input logic [AW-1:0] stat_addr,
  input logic [1:0]    stat_cmd,
  input logic [2:0]    stat_elem
);
  // R9
  halt_before_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(!mem_en));

  // R9
  no_op_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !mem_en);

  // R9
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> ($stable(stat_addr) && $stable(stat_cmd) && $stable(stat_elem)));

  // R8
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !fail));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en);

  // R2
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr >= lo_q && mem_addr <= hi_q));

  // R4
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_cmd != 2'b10);
endmodule

bind mbist_march_seq mbist_march_seq_chk #(.AW(AW)) u_assert (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .mem_en(mem_en), .mem_addr(mem_addr), .lo_q(lo_q),
  .hi_q(hi_q), .stat_addr(stat_addr), .stat_cmd(stat_cmd), .stat_elem(stat_elem)
);

// File: tb/mbist_march_seq_tb_top.sv
module mbist_march_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CELLS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    alg_sel = '0;
  logic [DW-1:0] pattern = '0;
  logic [AW-1:0] addr_lo = '0, addr_hi = '0;
  logic          mem_en, mem_we, busy, done, fail, stat_dir, stat_inv;
  logic [AW-1:0] mem_addr, stat_addr;
  logic [DW-1:0] mem_wdata, fail_exp, fail_act;
  logic [DW-1:0] mem_rdata = '0;
  logic [2:0]    stat_elem;
  logic [1:0]    stat_cmd;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_march_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .pattern(pattern),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .stat_elem(stat_elem),
    .stat_addr(stat_addr), .stat_dir(stat_dir), .stat_inv(stat_inv),
    .stat_cmd(stat_cmd), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // memory with an optional stuck bit
  bit          flt_on = 0;
  int          flt_addr = 0;
  int          flt_bit = 0;
  bit          flt_val = 0;
  logic [DW-1:0] mem    [CELLS];
  logic [DW-1:0] shadow [CELLS];

  function automatic logic [DW-1:0] stored(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] v;
    v = d;
    if (flt_on && a == flt_addr) v[flt_bit] = flt_val;
    return v;
  endfunction

  initial for (int i = 0; i < CELLS; i++) begin mem[i] = '0; shadow[i] = '0; end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= stored(int'(mem_addr), mem_wdata);
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: expected operation stream
  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [2:0]    elem;
    logic          dir;
    logic          inv;
    logic [1:0]    cmd;
  } op_t;

  op_t ops[$];
  bit  m_fail;
  logic [DW-1:0] m_exp, m_act;
  int  m_lo, m_hi;
  logic [DW-1:0] m_pat;

  task automatic march_pass(input int el, input bit down, input int nops,
                            input bit r0, input bit i0, input bit r1, input bit i1);
    for (int n = 0; n <= m_hi - m_lo; n++) begin
      int a;
      a = down ? m_hi - n : m_lo + n;
      for (int j = 0; j < nops; j++) begin
        op_t o;
        bit rd, iv;
        logic [DW-1:0] d;
        if (m_fail) return;
        rd = (j == 0) ? r0 : r1;
        iv = (j == 0) ? i0 : i1;
        d  = iv ? ~m_pat : m_pat;
        o.we = !rd; o.addr = AW'(a); o.data = d; o.elem = 3'(el);
        o.dir = down; o.inv = iv; o.cmd = rd ? 2'd3 : 2'd1;
        ops.push_back(o);
        if (rd) begin
          if (shadow[a] != d) begin m_fail = 1; m_exp = d; m_act = shadow[a]; end
        end else begin
          shadow[a] = stored(a, d);
        end
      end
    end
  endtask

  task automatic build(input int alg);
    ops.delete();
    m_fail = 0;
    case (alg)
      0: march_pass(0, 0, 1, 0, 0, 0, 0);
      1: march_pass(0, 0, 1, 1, 0, 0, 0);
      2: begin
        march_pass(0, 0, 1, 0, 0, 0, 0); march_pass(1, 0, 1, 1, 0, 0, 0);
        march_pass(2, 0, 1, 0, 1, 0, 0); march_pass(3, 0, 1, 1, 1, 0, 0);
      end
      3: begin
        march_pass(0, 0, 1, 0, 0, 0, 0); march_pass(1, 0, 2, 1, 0, 0, 1);
        march_pass(2, 1, 2, 1, 1, 0, 0);
      end
      4: begin
        march_pass(0, 0, 1, 0, 0, 0, 0); march_pass(1, 0, 2, 1, 0, 0, 1);
        march_pass(2, 0, 2, 1, 1, 0, 0); march_pass(3, 1, 2, 1, 0, 0, 1);
        march_pass(4, 1, 2, 1, 1, 0, 0); march_pass(5, 1, 1, 1, 0, 0, 0);
      end
      default: ;
    endcase
  endtask

  task automatic run(input int alg, input logic [DW-1:0] pat, input int lo, input int hi,
                     input string req);
    int idx, k, due;
    bit had, fin;
    m_lo = lo; m_hi = hi; m_pat = pat;
    build(alg);
    due = (ops.size() == 0) ? 1 : ops.size() + 2;
    @(negedge clk);
    alg_sel = 3'(alg); pattern = pat; addr_lo = AW'(lo); addr_hi = AW'(hi); start = 1'b1;
    idx = 0; had = 0; fin = 0; k = 0;
    while (!fin && k < 4000) begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (k == 1 && ops.size() != 0)
        chk(busy && !fail && !done, "R10 busy after start", {busy, fail, done}, 3'b100);
      if (had)
        chk({stat_elem, stat_dir, stat_inv, stat_cmd, stat_addr} ==
            {ops[idx-1].elem, ops[idx-1].dir, ops[idx-1].inv, ops[idx-1].cmd, ops[idx-1].addr},
            "R10 stat fields",
            {stat_elem, stat_dir, stat_inv, stat_cmd, stat_addr},
            {ops[idx-1].elem, ops[idx-1].dir, ops[idx-1].inv, ops[idx-1].cmd, ops[idx-1].addr});
      had = 0;
      if (mem_en) begin
        if (idx < ops.size()) begin
          chk({mem_we, mem_addr, mem_we ? mem_wdata : 16'h0} ==
              {ops[idx].we, ops[idx].addr, ops[idx].we ? ops[idx].data : 16'h0},
              req, {mem_we, mem_addr, mem_wdata}, {ops[idx].we, ops[idx].addr, ops[idx].data});
          idx++;
          had = 1;
        end else begin
          chk(0, {req, " R9 extra operation"}, idx, ops.size());
        end
      end
      if (done || fail) fin = 1;
    end
    chk(fin, {req, " R8 completion"}, fin, 1);
    chk(k == due, {req, " R8 completion cycle"}, k, due);
    chk(idx == ops.size(), {req, " operation count"}, idx, ops.size());
    chk(fail == m_fail && done == !m_fail, {req, " R9 verdict"}, {done, fail}, {!m_fail, m_fail});
    if (m_fail) begin
      chk(fail_exp == m_exp, "R9 fail_exp", fail_exp, m_exp);
      chk(fail_act == m_act, "R9 fail_act", fail_act, m_act);
      chk(stat_addr == ops[ops.size()-1].addr && stat_cmd == 2'd3,
          "R9 frozen address and command", {stat_addr, stat_cmd}, {ops[ops.size()-1].addr, 2'd3});
    end
    @(negedge clk);
    chk(!mem_en && !busy, {req, " R8 idle after end"}, {mem_en, busy}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !fail && !mem_en && stat_cmd == 2'd0, "R1 in reset",
        {busy, done, fail, mem_en, stat_cmd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !fail && !mem_en && stat_cmd == 2'd0, "R1 after reset",
        {busy, done, fail, mem_en, stat_cmd}, 0);

    run(0, 16'hA5C3, 0, CELLS - 1, "R4 init");
    // R4: read-check on retained data, first command must be 3
    run(1, 16'hA5C3, 0, CELLS - 1, "R4 read-check");
    run(2, 16'h0F0F, 16, 63, "R5 scan");
    run(3, 16'h1234, 0, CELLS - 1, "R6 march5");
    run(4, 16'hFFFF, 128, 159, "R7 march10");
    run(4, 16'h6C39, 0, CELLS - 1, "R7 march10 full R3");
    run(6, 16'h0000, 0, 15, "R8 unused code");
    run(4, 16'h5A5A, 66, 66, "R2 single cell");
    run(3, 16'h3C3C, 250, 255, "R2 top of range");

    // R9: stuck-at-1 bit 3 seen in the descending element
    flt_on = 1; flt_addr = 37; flt_bit = 3; flt_val = 1;
    run(3, 16'h0008, 32, 47, "R9 descending fault");
    chk(stat_dir == 1'b1 && stat_inv == 1'b1 && stat_elem == 3'd2, "R9 frozen step",
        {stat_dir, stat_inv, stat_elem}, {1'b1, 1'b1, 3'd2});

    // R9: stuck-at-0 bit 0, failing read is followed by a write to the same cell
    flt_addr = 49; flt_bit = 0; flt_val = 0;
    run(4, 16'h0001, 48, 51, "R9 ascending fault R3");
    chk(stat_addr == 8'd49 && stat_elem == 3'd1 && stat_dir == 1'b0, "R9 frozen ascending",
        {stat_addr, stat_elem, stat_dir}, {8'd49, 3'd1, 1'b0});

    // R10: a clean run after a failure clears fail
    flt_on = 0;
    run(0, 16'h8001, 40, 60, "R10 restart");
    chk(done && !fail, "R10 fail cleared", {done, fail}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule